// File: doc/BRIEF.md
# Quadrature PLL Rotor Speed and Angle Tracker

This block tracks the electrical angle and angular speed of a permanent-magnet rotor from sampled estimates of the two stationary-frame back-EMF components. Each accepted sample updates the estimates once. The block reads the sine and cosine of its present angle estimate from an internal quarter-wave table. It forms a phase error from the two EMF components and that sine and cosine. A proportional-integral regulator turns the error into a speed estimate, and a wrapping phase accumulator integrates the speed into the angle.

The tracker is only meaningful once the rotor is already turning at a steady low speed under open-loop drive. Before handover, the control software holds `en` high and pulses `load` with the open-loop speed and angle. The integrator and the angle register then start from the right place and the loop takes over without a jump. The gains are small programmable values, so the loop bandwidth stays low.

Samples enter over a valid/ready handshake. The block holds one result in an output slot. While that result has not been taken (`out_valid` high and `out_ready` low), `in_ready` is low and the sample source has to wait. `in_ready` is also low while `en` is low and in any cycle where `load` is high. The gains, limits, preload values, `en` and `load` are plain control pins.

Top module: `qpll_tracker`

## Requirements
- R1: While `rst_n` is low or `en` is low, `speed`, `angle` and `out_valid` are zero at the next clock edge, and `in_ready` is low while `en` is low.
- R2: A clock edge with `en` and `load` high sets the integrator and `speed` to `preload_speed`, sets `angle` to `preload_angle`, and clears `out_valid`.
- R3: The phase error is floor((emf_b*S - emf_a*C) / 2^15), where S and C are the table sine and cosine of `angle`. Bits [15:14] of `angle` select the quadrant and bits [13:8] select k. With q(k) = floor(32767*k*(128-k)/4096), the sine is q(k), q(64-k), -q(k) or -q(64-k) for quadrants 0 to 3. The cosine is the sine of the next quadrant with the same k.
- R4: The phase error saturates to the signed 16-bit range [-32768, 32767].
- R5: On each accepted sample, the integrator becomes I + floor(ki*e/256), and the new `speed` becomes that integrator value plus floor(kp*e/256). Here `kp` and `ki` are unsigned and e is the phase error.
- R6: The integrator and `speed` are each clamped to [`spd_min`, `spd_max`], with the upper limit tested first. A saturated integrator therefore recovers on the very next sample of opposite error.
- R7: On each accepted sample, `angle` becomes the old `angle` plus the new sign-extended `speed`, modulo 2^16.
- R8: A sample is accepted when `in_valid` and `in_ready` are both high, and `in_ready` = `en` and not `load` and (not `out_valid` or `out_ready`). Acceptance sets `out_valid`. `out_valid` stays high, with `speed` and `angle` unchanged, until `out_ready` is seen high.
- R9: When `load` and `in_valid` are both high, the sample is not accepted and the preload values appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Tracker enable; low clears all state |
| load | input | 1 | Copy preload values into the integrator and angle |
| preload_speed | input | 16 | Signed open-loop speed, angle units per sample |
| preload_angle | input | 16 | Open-loop angle, 2^16 = one electrical turn |
| kp | input | 8 | Unsigned proportional gain, scaled by 1/256 |
| ki | input | 8 | Unsigned integral gain, scaled by 1/256 |
| spd_min | input | 16 | Signed lower speed clamp |
| spd_max | input | 16 | Signed upper speed clamp |
| in_valid | input | 1 | EMF sample present |
| in_ready | output | 1 | Tracker can accept a sample |
| emf_a | input | 16 | Signed alpha-axis back-EMF estimate |
| emf_b | input | 16 | Signed beta-axis back-EMF estimate |
| out_valid | output | 1 | Updated estimates waiting |
| out_ready | input | 1 | Consumer takes the estimates |
| speed | output | 16 | Signed estimated speed, angle units per sample |
| angle | output | 16 | Estimated electrical angle |

## Verification
A corrupted integrator shows in `speed` on the very next accepted sample, because the proportional path adds to it and does not hide it. A wrong angle register or wrong table entry changes the phase error used for that same update, so `speed` and `angle` both move off their expected values one sample after the fault. A handshake fault shows in the same cycle as a wrong `in_ready` level, or one edge later as outputs that change while the slot is held.

// File: rtl/qpll_pkg.sv
package qpll_pkg;

  // Quarter-wave parabolic sine: exact at 0 and at the quarter point.
  function automatic longint qsine(input longint k, input longint steps,
                                   input longint amp);
    return (amp * k * (2 * steps - k)) / (steps * steps);
  endfunction

  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;

endpackage

// File: rtl/qpll_trig.sv
module qpll_trig #(
  parameter int QB = 6,
  parameter int TW = 16
) (
  input  logic [QB+1:0]          ang_hi,
  output logic signed [TW-1:0]   sin_o,
  output logic signed [TW-1:0]   cos_o
);
  import qpll_pkg::*;

  localparam int N   = 1 << QB;
  localparam int AMP = (1 << (TW - 1)) - 1;

  logic signed [TW-1:0] tbl [N+1];

  for (genvar g = 0; g <= N; g++) begin : g_tbl
    assign tbl[g] = TW'(qsine(longint'(g), longint'(N), longint'(AMP)));
  end

  quad_e        qs, qc;
  logic [QB-1:0] k;
  logic [QB:0]   kr;

  assign qs = quad_e'(ang_hi[QB+1:QB]);
  assign qc = quad_e'(ang_hi[QB+1:QB] + 2'd1);
  assign k  = ang_hi[QB-1:0];
  assign kr = (QB+1)'(N) - {1'b0, k};

  always_comb begin
    unique case (qs)
      QUAD_0:  sin_o = tbl[k];
      QUAD_1:  sin_o = tbl[kr];
      QUAD_2:  sin_o = -tbl[k];
      default: sin_o = -tbl[kr];
    endcase
  end

  always_comb begin
    unique case (qc)
      QUAD_0:  cos_o = tbl[k];
      QUAD_1:  cos_o = tbl[kr];
      QUAD_2:  cos_o = -tbl[k];
      default: cos_o = -tbl[kr];
    endcase
  end

endmodule

// File: rtl/qpll_phase_det.sv
module qpll_phase_det #(
  parameter int EW = 16,
  parameter int TW = 16
) (
  input  logic signed [EW-1:0] ea,
  input  logic signed [EW-1:0] eb,
  input  logic signed [TW-1:0] s,
  input  logic signed [TW-1:0] c,
  output logic signed [EW-1:0] err
);
  localparam int PW = EW + TW + 1;
  localparam logic signed [PW-1:0] HI = PW'((longint'(1) << (EW - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -PW'(longint'(1) << (EW - 1));

  logic signed [PW-1:0] pb, pa, raw, sh;

  assign pb  = eb * s;
  assign pa  = ea * c;
  assign raw = pb - pa;
  assign sh  = raw >>> (TW - 1);

  always_comb begin
    if (sh > HI)      err = HI[EW-1:0];
    else if (sh < LO) err = LO[EW-1:0];
    else              err = sh[EW-1:0];
  end

endmodule

// File: rtl/qpll_pi.sv
module qpll_pi #(
  parameter int EW = 16,
  parameter int GW = 8,
  parameter int SW = 16,
  parameter int KS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic                 step,
  input  logic signed [SW-1:0] preload,
  input  logic signed [EW-1:0] err,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic signed [SW-1:0] lo,
  input  logic signed [SW-1:0] hi,
  output logic signed [SW-1:0] speed_nxt
);
  localparam int MW = EW + GW + 1;
  localparam int IW = ((SW > MW) ? SW : MW) + 2;

  logic signed [SW-1:0] integ_q, integ_nxt;
  logic signed [MW-1:0] pprod, iprod;
  logic signed [IW-1:0] pterm, iterm, isum, ssum;

  function automatic logic signed [SW-1:0] clamp(
    input logic signed [IW-1:0] v,
    input logic signed [SW-1:0] l,
    input logic signed [SW-1:0] h);
    if (v > IW'(h))      return h;
    else if (v < IW'(l)) return l;
    else                 return v[SW-1:0];
  endfunction

  assign pprod = err * $signed({1'b0, kp});
  assign iprod = err * $signed({1'b0, ki});
  assign pterm = IW'(pprod >>> KS);
  assign iterm = IW'(iprod >>> KS);

  assign isum      = IW'(integ_q) + iterm;
  assign integ_nxt = clamp(isum, lo, hi);
  assign ssum      = IW'(integ_nxt) + pterm;
  assign speed_nxt = clamp(ssum, lo, hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    integ_q <= '0;
    else if (clr)  integ_q <= '0;
    else if (load) integ_q <= preload;
    else if (step) integ_q <= integ_nxt;
  end

endmodule

// File: rtl/qpll_tracker.sv
module qpll_tracker #(
  parameter int EW = 16,
  parameter int TW = 16,
  parameter int AW = 16,
  parameter int QB = 6,
  parameter int GW = 8,
  parameter int SW = 16,
  parameter int KS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 load,
  input  logic signed [SW-1:0] preload_speed,
  input  logic [AW-1:0]        preload_angle,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic signed [SW-1:0] spd_min,
  input  logic signed [SW-1:0] spd_max,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [EW-1:0] emf_a,
  input  logic signed [EW-1:0] emf_b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] speed,
  output logic [AW-1:0]        angle
);
  logic signed [TW-1:0] s_v, c_v;
  logic signed [EW-1:0] err;
  logic signed [SW-1:0] spd_nxt;
  logic signed [AW-1:0] spd_ext;
  logic                 accept;
  logic                 ov_q;
  logic signed [SW-1:0] spd_q;
  logic [AW-1:0]        ang_q;

  assign in_ready = en && !load && (!ov_q || out_ready);
  assign accept   = in_valid && in_ready;

  qpll_trig #(.QB(QB), .TW(TW)) u_trig (
    .ang_hi (ang_q[AW-1 -: QB+2]),
    .sin_o  (s_v),
    .cos_o  (c_v)
  );

  qpll_phase_det #(.EW(EW), .TW(TW)) u_pd (
    .ea  (emf_a),
    .eb  (emf_b),
    .s   (s_v),
    .c   (c_v),
    .err (err)
  );

  qpll_pi #(.EW(EW), .GW(GW), .SW(SW), .KS(KS)) u_pi (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en),
    .load      (load),
    .step      (accept),
    .preload   (preload_speed),
    .err       (err),
    .kp        (kp),
    .ki        (ki),
    .lo        (spd_min),
    .hi        (spd_max),
    .speed_nxt (spd_nxt)
  );

  assign spd_ext = AW'(spd_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= '0;
      ang_q <= '0;
      ov_q  <= 1'b0;
    end else if (!en) begin
      spd_q <= '0;
      ang_q <= '0;
      ov_q  <= 1'b0;
    end else if (load) begin
      spd_q <= preload_speed;
      ang_q <= preload_angle;
      ov_q  <= 1'b0;
    end else if (accept) begin
      spd_q <= spd_nxt;
      ang_q <= ang_q + spd_ext;
      ov_q  <= 1'b1;
    end else if (out_ready) begin
      ov_q  <= 1'b0;
    end
  end

  assign speed     = spd_q;
  assign angle     = ang_q;
  assign out_valid = ov_q;

endmodule

// File: rtl/qpll_tracker_chk.sv
module qpll_tracker_chk #(
  parameter int AW = 16,
  parameter int SW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 load,
  input logic signed [SW-1:0] preload_speed,
  input logic [AW-1:0]        preload_angle,
  input logic signed [SW-1:0] spd_min,
  input logic signed [SW-1:0] spd_max,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [SW-1:0] speed,
  input logic [AW-1:0]        angle
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_off_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (speed == '0 && angle == '0 && !out_valid));

  p_off_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_ready);

  p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (speed == $past(preload_speed) &&
                      angle == $past(preload_angle) && !out_valid));

  p_speed_limits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && en && spd_min <= spd_max) |=>
      (speed <= $past(spd_max) && speed >= $past(spd_min)));

  p_angle_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && en) |=> (angle == AW'($past(angle) + AW'(speed))));

  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && out_valid && !out_ready) |=>
      (out_valid && $stable(speed) && $stable(angle)));

  p_load_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !in_ready);

endmodule

bind qpll_tracker qpll_tracker_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .load          (load),
  .preload_speed (preload_speed),
  .preload_angle (preload_angle),
  .spd_min       (spd_min),
  .spd_max       (spd_max),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .speed         (speed),
  .angle         (angle)
);

// File: tb/test_qpll_tracker.sv
module test_qpll_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, load = 1'b0;
  logic signed [15:0] preload_speed = '0;
  logic [15:0] preload_angle = '0;
  logic [7:0] kp = 8'd16, ki = 8'd4;
  logic signed [15:0] spd_min = -16'sd4000, spd_max = 16'sd4000;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] emf_a = '0, emf_b = '0;
  logic in_ready, out_valid;
  logic signed [15:0] speed;
  logic [15:0] angle;

  int total = 0, bad = 0;
  bit done = 0;
  longint m_int = 0, m_spd = 0, m_ang = 0;

  always #10 clk = ~clk;

  qpll_tracker i_qpll_tracker (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .preload_speed(preload_speed), .preload_angle(preload_angle),
    .kp(kp), .ki(ki), .spd_min(spd_min), .spd_max(spd_max),
    .in_valid(in_valid), .in_ready(in_ready),
    .emf_a(emf_a), .emf_b(emf_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .speed(speed), .angle(angle)
  );

  task automatic chk(input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic longint qv(input longint k);
    return (32767 * k * (128 - k)) / 4096;
  endfunction

  function automatic longint bsin(input longint a);
    longint q, k;
    q = (a >> 14) & 3;
    k = (a >> 8) & 63;
    case (q)
      0: return qv(k);
      1: return qv(64 - k);
      2: return -qv(k);
      default: return -qv(64 - k);
    endcase
  endfunction

  function automatic longint bcos(input longint a);
    return bsin((a + 16384) & 65535);
  endfunction

  function automatic longint lim(input longint v);
    if (v > longint'(spd_max)) return longint'(spd_max);
    if (v < longint'(spd_min)) return longint'(spd_min);
    return v;
  endfunction

  task automatic model_step(input longint ea, input longint eb);
    longint raw, e;
    raw = eb * bsin(m_ang) - ea * bcos(m_ang);
    e = raw >>> 15;
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    m_int = lim(m_int + ((longint'(ki) * e) >>> 8));
    m_spd = lim(m_int + ((longint'(kp) * e) >>> 8));
    m_ang = (m_ang + m_spd) & 65535;
  endtask

  task automatic sample(input longint ea, input longint eb, input string rq);
    @(negedge clk);
    in_valid = 1'b1;
    emf_a = 16'(ea);
    emf_b = 16'(eb);
    #1;
    chk({rq, " in_ready"}, in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    model_step(ea, eb);
    chk({rq, " speed"}, speed, m_spd);
    chk({rq, " angle"}, angle, m_ang);
    chk({rq, " out_valid"}, out_valid, 1);
  endtask

  task automatic preload(input longint ps, input longint pa);
    @(negedge clk);
    load = 1'b1;
    preload_speed = 16'(ps);
    preload_angle = 16'(pa);
    @(negedge clk);
    load = 1'b0;
    m_int = ps; m_spd = ps; m_ang = pa & 65535;
  endtask

  task automatic t_reset;
    chk("R1 reset speed", speed, 0);
    chk("R1 reset angle", angle, 0);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 ready low while off", in_ready, 0);
  endtask

  task automatic t_preload;
    preload(100, 16'h4000);
    chk("R2 preload speed", speed, 100);
    chk("R2 preload angle", angle, 16'h4000);
    chk("R2 preload out_valid", out_valid, 0);
  endtask

  task automatic t_track;
    preload(100, 0);
    sample(-1000, 0, "R3 angle0");
    sample(-1000, 500, "R5 mixed");
    preload(0, 16'h8000);
    sample(3000, -2000, "R3 quadrant2");
    preload(0, 16'hC400);
    sample(-700, 1500, "R5 quadrant3");
  endtask

  task automatic t_saturate;
    preload(0, 16'h2000);
    sample(-32768, 32767, "R4 err saturate");
  endtask

  task automatic t_clamp;
    longint prev;
    ki = 8'd64; spd_max = 16'sd300; spd_min = -16'sd300;
    preload(0, 0);
    for (int i = 0; i < 3; i++) sample(-20000, 0, "R6 upper clamp");
    chk("R6 at upper limit", speed, 300);
    prev = m_spd;
    sample(1000, 1000, "R6 recover");
    total++;
    if (!(m_spd < prev)) begin
      bad++;
      $display("FAIL R6 recover: got %0d expected below %0d", m_spd, prev);
    end
    ki = 8'd4; spd_max = 16'sd4000; spd_min = -16'sd4000;
  endtask

  task automatic t_wrap;
    preload(16'h200, 16'hFF00);
    sample(0, 0, "R7 forward wrap");
    chk("R7 wrapped angle", angle, 16'h0100);
    preload(-64, 16'h0010);
    sample(0, 0, "R7 backward wrap");
    chk("R7 wrapped back", angle, 16'hFFD0);
  endtask

  task automatic t_backpressure;
    preload(50, 16'h1000);
    out_ready = 1'b0;
    sample(-900, 200, "R8 accept");
    @(negedge clk);
    in_valid = 1'b1; emf_a = 16'sd5000; emf_b = 16'sd5000;
    #1;
    chk("R8 ready low when slot full", in_ready, 0);
    @(negedge clk);
    chk("R8 speed held", speed, m_spd);
    chk("R8 angle held", angle, m_ang);
    chk("R8 valid held", out_valid, 1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 valid drops after take", out_valid, 0);
  endtask

  task automatic t_load_priority;
    @(negedge clk);
    load = 1'b1; in_valid = 1'b1;
    preload_speed = 16'sd77; preload_angle = 16'h1234;
    emf_a = 16'sd9000; emf_b = -16'sd9000;
    #1;
    chk("R9 ready low under load", in_ready, 0);
    @(negedge clk);
    load = 1'b0; in_valid = 1'b0;
    m_int = 77; m_spd = 77; m_ang = 16'h1234;
    chk("R9 preload speed wins", speed, 77);
    chk("R9 preload angle wins", angle, 16'h1234);
    sample(0, 0, "R9 integrator loaded");
  endtask

  task automatic t_disable;
    @(negedge clk);
    en = 1'b0;
    in_valid = 1'b1; emf_a = 16'sd3000;
    @(negedge clk);
    chk("R1 off speed", speed, 0);
    chk("R1 off angle", angle, 0);
    chk("R1 off valid", out_valid, 0);
    chk("R1 off ready", in_ready, 0);
    in_valid = 1'b0;
    en = 1'b1;
    m_int = 0; m_spd = 0; m_ang = 0;
    sample(0, 0, "R1 integrator cleared");
  endtask

  initial begin
    #35;
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    en = 1'b1;
    t_preload;
    t_track;
    t_saturate;
    t_clamp;
    t_wrap;
    t_backpressure;
    t_load_priority;
    t_disable;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule